// File: doc/BRIEF.md
# Register-Mapped EEPROM Access Controller

This block gives a CPU access to a 64-byte non-volatile byte store through three registers on its I/O bus: one that selects a byte, one that holds the byte, and one that starts operations. Software sets the byte index, then starts a read that loads the data register from the store. To write, software loads the data register and sets a start bit. The block times the write by itself and keeps that bit set until the byte is committed, so software polls it to learn when the store is free again.

Every accepted read or write start holds the CPU through a stall output for two clock cycles. The store is modelled as an internal 64x8 array. It powers up erased (every byte 0xFF) and keeps its contents across reset. The write time is a parameter counted in clock cycles. The default stands for a few milliseconds, and a bench can make it short.

The I/O bus is a plain single-cycle register port (`io_we` / `io_re` with an address). It has no back-pressure: a register write always takes effect at the next clock edge, and a register read returns data in the same cycle.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the three registers read 0x00 and `cpu_stall` is low. A reset mid-run clears the registers again.
- R2: The address register sits at I/O address 0x1E. Its bits 5..0 are writable and select byte 0..63. Bits 7..6 ignore writes and read as zero.
- R3: The data register sits at I/O address 0x1D and reads back what was written. A read of any unmapped I/O address, or with `io_re` low, returns 0x00.
- R4: The control register sits at I/O address 0x1C. Bit 0 is the read flag and bit 1 is the write-busy flag. Bits 7..2 always read as zero. Writing 0 to bits 1..0 while idle starts nothing.
- R5: Writing the control register with bit 0 = 1 and bit 1 = 0 while idle starts a read. At the next edge the data register is loaded with the addressed byte. Bit 0 reads 1 until one cycle after that load, then clears itself.
- R6: Writing the control register with bit 1 = 1 while idle latches the address and data registers. Bit 1 then reads 1 for exactly WR_CYCLES cycles. When it clears, the latched byte is in the store.
- R7: Every accepted read or write start drives `cpu_stall` high for exactly two cycles, beginning the cycle after the control write.
- R8: While bit 1 is set, a read start is ignored: bit 0 stays 0 and there is no stall. Writing 0 to bit 1 does not cancel the write. Address and data register writes are accepted, but the write in flight still commits the values latched at its start.
- R9: A control write with both bits 0 and 1 set while idle starts only the write. Bit 0 reads 0.
- R10: If an I/O write to the data register falls in the same cycle as a read's load, the byte from the store wins.
- R11: At power-up every byte of the store reads 0xFF, and reset does not alter the store.
- R12: Both ends of the byte range, index 0 and index 63, are reachable for reading and writing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free, synchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_we | input | 1 | I/O write strobe, single cycle |
| io_re | input | 1 | I/O read strobe; gates `io_rdata` |
| io_rdata | output | 8 | I/O read data, combinational from `io_addr` |
| cpu_stall | output | 1 | Holds the CPU for two cycles after each accepted start |

## Verification
Two functions can land on the same clock edge: the store-to-data-register load of a read, and a software write to the data register. The bench starts a read and, in the very next cycle, writes 0x55 to the data register. It then requires the register to hold the stored byte rather than 0x55, and a later plain write must still land. A second overlap is a read start issued while a timed write is busy. Here the bench requires that the control register shows only the busy bit, that no stall is raised, and that the pending write still commits the values it latched.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int IO_AW = 6;
  localparam int DW    = 8;

  localparam logic [IO_AW-1:0] IOA_CTRL = 6'h1C;
  localparam logic [IO_AW-1:0] IOA_DATA = 6'h1D;
  localparam logic [IO_AW-1:0] IOA_ADDR = 6'h1E;

  localparam int CTRL_RD = 0;
  localparam int CTRL_WR = 1;

  typedef struct packed {
    logic addr_wr;
    logic data_wr;
    logic rd_req;
    logic wr_req;
  } io_strobe_t;
endpackage

// File: rtl/nvm_decode.sv
module nvm_decode
  import nvm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       ctrl_bits,
  input  logic             io_we,
  input  logic             io_re,
  input  logic [AW-1:0]    addr_q,
  input  logic [DW-1:0]    data_q,
  input  logic             rd_flag,
  input  logic             wr_busy,
  output io_strobe_t       stb,
  output logic [DW-1:0]    io_rdata
);
  localparam int PAD = DW - AW;

  always_comb begin
    stb = '0;
    if (io_we) begin
      case (io_addr)
        IOA_ADDR: stb.addr_wr = 1'b1;
        IOA_DATA: stb.data_wr = 1'b1;
        IOA_CTRL: begin
          stb.rd_req = ctrl_bits[CTRL_RD];
          stb.wr_req = ctrl_bits[CTRL_WR];
        end
        default: stb = '0;
      endcase
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_re) begin
      case (io_addr)
        IOA_ADDR: io_rdata = {{PAD{1'b0}}, addr_q};
        IOA_DATA: io_rdata = data_q;
        IOA_CTRL: begin
          io_rdata[CTRL_WR] = wr_busy;
          io_rdata[CTRL_RD] = rd_flag;
        end
        default: io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_wtimer.sv
module nvm_wtimer #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(WR_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(1);

  logic [TW-1:0] cnt;

  assign commit = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      c_addr <= '0;
      c_data <= '0;
    end else if (go) begin
      busy   <= 1'b1;
      cnt    <= LOAD;
      c_addr <= addr_in;
      c_data <= data_in;
    end else if (busy) begin
      cnt <= cnt - LAST;
      if (cnt == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
  parameter int STALL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic stall
);
  localparam int SW = $clog2(STALL_CYCLES + 1);
  localparam logic [SW-1:0] LOAD = SW'(STALL_CYCLES);
  localparam logic [SW-1:0] ONE  = SW'(1);

  logic [SW-1:0] cnt;

  assign stall = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (go)     cnt <= LOAD;
    else if (stall)  cnt <= cnt - ONE;
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH] = '{default: {DW{1'b1}}};

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int WR_CYCLES    = 40000,
  parameter int STALL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_we,
  input  logic             io_re,
  output logic [DW-1:0]    io_rdata,
  output logic             cpu_stall
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rd_flag;
  logic          rd_done;
  logic          wr_busy;
  io_strobe_t    stb;
  logic          wr_go;
  logic          rd_go;
  logic          rd_load;
  logic          commit;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic [DW-1:0] mem_rdata;

  nvm_decode #(.AW(AW)) u_decode (
    .io_addr  (io_addr),
    .ctrl_bits(io_wdata[1:0]),
    .io_we    (io_we),
    .io_re    (io_re),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .rd_flag  (rd_flag),
    .wr_busy  (wr_busy),
    .stb      (stb),
    .io_rdata (io_rdata)
  );

  // Starts are accepted only when no operation is pending; write has priority.
  assign wr_go   = stb.wr_req && !wr_busy && !rd_flag;
  assign rd_go   = stb.rd_req && !stb.wr_req && !wr_busy && !rd_flag;
  assign rd_load = rd_flag && !rd_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      rd_flag <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      if (stb.addr_wr) addr_q <= io_wdata[AW-1:0];

      if (rd_load)          data_q <= mem_rdata;
      else if (stb.data_wr) data_q <= io_wdata;

      if (rd_go) begin
        rd_flag <= 1'b1;
      end else if (rd_done) begin
        rd_flag <= 1'b0;
        rd_done <= 1'b0;
      end else if (rd_load) begin
        rd_done <= 1'b1;
      end
    end
  end

  nvm_wtimer #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_wtimer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (wr_go),
    .addr_in(addr_q),
    .data_in(data_q),
    .busy   (wr_busy),
    .commit (commit),
    .c_addr (c_addr),
    .c_data (c_data)
  );

  nvm_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (wr_go || rd_go),
    .stall(cpu_stall)
  );

  nvm_store #(.AW(AW), .DW(DW)) u_store (
    .clk  (clk),
    .we   (commit),
    .waddr(c_addr),
    .wdata(c_data),
    .raddr(addr_q),
    .rdata(mem_rdata)
  );
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [IO_AW-1:0] io_addr,
  input logic [1:0]       ctrl_bits,
  input logic             io_we,
  input logic             io_re,
  input logic [5:0]       rd_hi,
  input logic             cpu_stall,
  input logic             wr_busy,
  input logic             rd_flag
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |=> cpu_stall);

  // R7
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && $past(cpu_stall)) |=> !cpu_stall);

  // R6
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == IOA_CTRL && ctrl_bits[CTRL_WR] && !wr_busy && !rd_flag)
      |=> (wr_busy && cpu_stall));

  // R8
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && io_we && io_addr == IOA_CTRL && ctrl_bits[CTRL_RD]) |=> !rd_flag);

  // R4
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_re && io_addr == IOA_CTRL) |-> (rd_hi == 6'd0));

  // R2
  addr_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_re && io_addr == IOA_ADDR) |-> (rd_hi[5:4] == 2'd0));
endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_addr  (io_addr),
  .ctrl_bits(io_wdata[1:0]),
  .io_we    (io_we),
  .io_re    (io_re),
  .rd_hi    (io_rdata[7:2]),
  .cpu_stall(cpu_stall),
  .wr_busy  (wr_busy),
  .rd_flag  (rd_flag)
);

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
  localparam int WR = 20;
  localparam logic [5:0] A_CTRL = 6'h1C;
  localparam logic [5:0] A_DATA = 6'h1D;
  localparam logic [5:0] A_ADDR = 6'h1E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_we = 1'b0;
  logic       io_re = 1'b0;
  logic [7:0] io_rdata;
  logic       cpu_stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm_ctrl #(.WR_CYCLES(WR)) i_nvm_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_we    (io_we),
    .io_re    (io_re),
    .io_rdata (io_rdata),
    .cpu_stall(cpu_stall)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Called on a falling edge; drives one write across the next rising edge.
  task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
    io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic io_rd(input logic [5:0] a, output logic [7:0] d);
    io_re = 1'b1; io_addr = a;
    #1;
    d = io_rdata;
    io_re = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] c;
    n = 0;
    io_rd(A_CTRL, c);
    while (c[1] && n < 1000) begin
      @(negedge clk);
      n++;
      io_rd(A_CTRL, c);
    end
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] d);
    io_wr(A_ADDR, {2'b00, a});
    io_wr(A_CTRL, 8'h01);
    @(negedge clk);
    @(negedge clk);
    io_rd(A_DATA, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    io_rd(A_ADDR, v); chk("R1 addr reg", v, 8'h00);
    io_rd(A_DATA, v); chk("R1 data reg", v, 8'h00);
    io_rd(A_CTRL, v); chk("R1 ctrl reg", v, 8'h00);
    chk("R1 stall", {7'd0, cpu_stall}, 8'h00);
    io_rd(6'h10, v); chk("R3 unmapped read", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    io_wr(A_ADDR, 8'hFF);
    io_rd(A_ADDR, v); chk("R2 reserved bits zero", v, 8'h3F);
    io_wr(A_DATA, 8'hA5);
    io_rd(A_DATA, v); chk("R3 data readback", v, 8'hA5);
    io_addr = A_DATA; #1;
    chk("R3 no io_re gives zero", io_rdata, 8'h00);
    io_wr(A_CTRL, 8'hFC);
    io_rd(A_CTRL, v); chk("R4 reserved ctrl bits", v, 8'h00);
    chk("R4 no start no stall", {7'd0, cpu_stall}, 8'h00);
  endtask

  task automatic t_read_erased;
    logic [7:0] v;
    io_wr(A_ADDR, 8'h05);
    io_wr(A_CTRL, 8'h01);
    chk("R7 stall cycle 1", {7'd0, cpu_stall}, 8'h01);
    io_rd(A_CTRL, v); chk("R5 read flag set", v, 8'h01);
    @(negedge clk);
    chk("R7 stall cycle 2", {7'd0, cpu_stall}, 8'h01);
    io_rd(A_DATA, v); chk("R11 erased byte", v, 8'hFF);
    io_rd(A_CTRL, v); chk("R5 flag held after load", v, 8'h01);
    @(negedge clk);
    chk("R7 stall ends", {7'd0, cpu_stall}, 8'h00);
    io_rd(A_CTRL, v); chk("R5 flag self-clears", v, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] v;
    int n;
    io_wr(A_ADDR, 8'h05);
    io_wr(A_DATA, 8'h3C);
    io_wr(A_CTRL, 8'h02);
    chk("R7 write stall 1", {7'd0, cpu_stall}, 8'h01);
    io_rd(A_CTRL, v); chk("R6 busy set", v, 8'h02);
    @(negedge clk);
    chk("R7 write stall 2", {7'd0, cpu_stall}, 8'h01);
    @(negedge clk);
    chk("R7 write stall ends", {7'd0, cpu_stall}, 8'h00);
    wait_idle(n);
    chk("R6 busy duration", 8'(n + 2), 8'(WR));
    do_read(6'd5, v); chk("R6 committed byte", v, 8'h3C);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    int n;
    io_wr(A_ADDR, 8'h07);
    io_wr(A_DATA, 8'h11);
    io_wr(A_CTRL, 8'h02);
    io_wr(A_ADDR, 8'h09);
    io_wr(A_DATA, 8'h99);
    @(negedge clk);
    io_wr(A_CTRL, 8'h01);
    chk("R8 read ignored no stall", {7'd0, cpu_stall}, 8'h00);
    io_rd(A_CTRL, v); chk("R8 read flag stays 0", v, 8'h02);
    io_wr(A_CTRL, 8'h00);
    io_rd(A_CTRL, v); chk("R8 write not cancelled", v, 8'h02);
    io_rd(A_DATA, v); chk("R8 data write accepted", v, 8'h99);
    io_rd(A_ADDR, v); chk("R8 addr write accepted", v, 8'h09);
    wait_idle(n);
    do_read(6'd7, v); chk("R8 latched values used", v, 8'h11);
    do_read(6'd9, v); chk("R8 new addr untouched", v, 8'hFF);
  endtask

  task automatic t_both;
    logic [7:0] v;
    int n;
    io_wr(A_ADDR, 8'h09);
    io_wr(A_DATA, 8'h99);
    io_wr(A_CTRL, 8'h03);
    io_rd(A_CTRL, v); chk("R9 only write starts", v, 8'h02);
    chk("R9 stall", {7'd0, cpu_stall}, 8'h01);
    wait_idle(n);
    do_read(6'd9, v); chk("R9 write landed", v, 8'h99);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    io_wr(A_ADDR, 8'h05);
    io_wr(A_CTRL, 8'h01);
    io_wr(A_DATA, 8'h55);
    io_rd(A_DATA, v); chk("R10 load beats io write", v, 8'h3C);
    @(negedge clk);
    io_wr(A_DATA, 8'h55);
    io_rd(A_DATA, v); chk("R10 later write lands", v, 8'h55);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    int n;
    io_wr(A_ADDR, 8'h3F);
    io_wr(A_DATA, 8'hC3);
    io_wr(A_CTRL, 8'h02);
    wait_idle(n);
    do_read(6'd63, v); chk("R12 top index", v, 8'hC3);
    do_read(6'd0, v);  chk("R12 bottom index", v, 8'hFF);
  endtask

  task automatic t_reset_keep;
    logic [7:0] v;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    io_rd(A_ADDR, v); chk("R1 addr cleared mid-run", v, 8'h00);
    io_rd(A_DATA, v); chk("R1 data cleared mid-run", v, 8'h00);
    do_read(6'd5, v); chk("R11 store kept over reset", v, 8'h3C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_read_erased();
    t_write();
    t_busy();
    t_both();
    t_collide();
    t_edges();
    t_reset_keep();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule